// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers a small set of shared, level-sensitive PCI interrupt request lines onto the inputs of a legacy interrupt controller. Each request line owns one byte-wide steering register. A value below the controller input count selects the output that the line drives. A larger value leaves the line unconnected, and its level is then ignored. Every controller output is the OR of all request lines currently steered to it, so several lines may share one output.

Internally the block keeps a registered level map with one bit per (output, request line) pair. Bit `output * NUM_PIRQ + line` holds the level of that line when the line is steered to that output. The map is rebuilt from scratch on every clock from the present input levels and the present steering, so a steering change takes effect on the next rebuild with nothing stale left behind. The steering registers sit in a byte-addressed configuration window. Two combinational helpers sit beside the datapath. The first reports the route of any request line. The second maps a device/function number and an INTx pin onto a request-line index with the usual slot rotation.

Top module: `pirq_router`

## Requirements
- R1: While `rst` is high on a clock edge, every steering register returns to 0x80 and the level map clears, so after reset every `irq_out` bit is 0 and reads of 0x60..0x63 return 0x80.
- R2: A write with `cfg_addr` = 0x60 updates steering register i (line i, i = 0..3, byte address 0x60+i) from `cfg_wdata[8i+7:8i]` only when `cfg_be[i]` is 1. Registers whose enable bit is 0 keep their value.
- R3: A write to any other `cfg_addr` changes no steering register. A read of `cfg_rd_addr` outside 0x60..0x63 returns 0x00.
- R4: When line p is steered to output k (register value k < 16), `irq_out[k]` follows `pirq_lvl[p]` one clock edge after the level is sampled.
- R5: When a steering register holds 16 or more, that line drives no output, whatever its level.
- R6: An output to which several lines are steered is high while any of those lines is high.
- R7: After a steering write, outputs still show the old steering for one cycle. From the second clock edge after the write edge they show the new steering with the held input levels, and an output that is no longer targeted falls.
- R8: The route query for line `q_pin` gives `q_en`=1 and `q_irq` = register value when the value is below 16. Otherwise it gives `q_en`=0 and `q_irq`=0xFF.
- R9: The slot helper returns `(sw_intx + (sw_devfn >> 3) - 1) mod 4` on `sw_pirq`.

Routing register reset value and field layout: one byte per line, bit 7 set at reset (value 0x80, disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_lvl | input | 4 | Request line levels, bit i = line i |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write byte address (window base 0x60) |
| cfg_be | input | 4 | Byte enables, bit i selects steering register i |
| cfg_wdata | input | 32 | Write data, byte i for register i |
| cfg_rd_addr | input | 8 | Read byte address |
| cfg_rdata | output | 8 | Read data (combinational) |
| irq_out | output | 16 | Controller input levels |
| q_pin | input | 2 | Route query line index |
| q_en | output | 1 | Queried line is routed |
| q_irq | output | 8 | Queried output number, 0xFF if unrouted |
| sw_devfn | input | 8 | Device/function number for the slot helper |
| sw_intx | input | 2 | INTx pin (0 = INTA) for the slot helper |
| sw_pirq | output | 2 | Resulting request line index |

## Verification
A change of input level is due on `irq_out` one clock edge after it is sampled. A steering write is due two edges after the cycle in which it is driven: one edge latches the register and the next rebuilds the map. The driver records each expectation with the exact cycle number it is due, and the monitor compares `irq_out` on the falling edge of that cycle only. After each write it also checks the intermediate cycle, where the old steering must still show. The read, query and slot-helper ports are combinational and are checked shortly after their inputs settle.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

    localparam int unsigned PIRQ_N    = 4;
    localparam int unsigned IRQ_N     = 16;
    localparam int unsigned CFG_AW    = 8;
    localparam int unsigned ROUTE_OFF = 32'h60;
    localparam logic [7:0]  ROUTE_RST = 8'h80;

    typedef logic [7:0] route_t;

    typedef struct packed {
        logic   en;
        route_t irq;
    } route_rsp_t;

    // A steering byte is live when it names an existing controller input.
    function automatic logic route_live(route_t r, int unsigned n_irq);
        return 32'(r) < n_irq;
    endfunction

    function automatic route_rsp_t route_decode(route_t r, int unsigned n_irq);
        route_rsp_t rsp;
        rsp.en  = route_live(r, n_irq);
        rsp.irq = rsp.en ? r : 8'hFF;
        return rsp;
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_route_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = PIRQ_N,
    parameter int unsigned BASE     = ROUTE_OFF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [CFG_AW-1:0]           addr,
    input  logic [NUM_PIRQ-1:0]         be,
    input  logic [8*NUM_PIRQ-1:0]       wdata,
    input  logic [CFG_AW-1:0]           rd_addr,
    output route_t                      rdata,
    output route_t [NUM_PIRQ-1:0]       routes
);

    localparam int unsigned LAST = BASE + NUM_PIRQ;

    logic hit;
    assign hit = wr && (32'(addr) == BASE);

    for (genvar g = 0; g < NUM_PIRQ; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                routes[g] <= ROUTE_RST;
            end else if (hit && be[g]) begin
                routes[g] <= wdata[8*g +: 8];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PIRQ; i++) begin
            if (32'(rd_addr) == BASE + 32'(i)) begin
                rdata = routes[i];
            end
        end
        if (32'(rd_addr) >= LAST) begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_route_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = PIRQ_N,
    parameter int unsigned NUM_IRQ  = IRQ_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PIRQ-1:0]     lvl,
    input  route_t [NUM_PIRQ-1:0]   routes,
    output logic [NUM_IRQ-1:0]      irq_out
);

    localparam int unsigned MAP_W = NUM_IRQ * NUM_PIRQ;

    logic [MAP_W-1:0] map_q;
    logic [MAP_W-1:0] map_d;

    // Rebuilt from nothing each cycle: bit k*NUM_PIRQ+p holds line p on input k.
    always_comb begin
        map_d = '0;
        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int p = 0; p < NUM_PIRQ; p++) begin
                map_d[k*NUM_PIRQ + p] = lvl[p]
                                      && route_live(routes[p], NUM_IRQ)
                                      && (32'(routes[p]) == 32'(k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_or
        assign irq_out[g] = |map_q[g*NUM_PIRQ +: NUM_PIRQ];
    end

endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query
    import pirq_route_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = PIRQ_N,
    parameter int unsigned NUM_IRQ  = IRQ_N,
    localparam int unsigned PIN_W   = $clog2(NUM_PIRQ)
) (
    input  route_t [NUM_PIRQ-1:0]   routes,
    input  logic [PIN_W-1:0]        q_pin,
    output route_rsp_t              q_rsp,
    input  logic [7:0]              sw_devfn,
    input  logic [PIN_W-1:0]        sw_intx,
    output logic [PIN_W-1:0]        sw_pirq
);

    assign q_rsp = route_decode(routes[q_pin], NUM_IRQ);

    // Slot rotation; NUM_PIRQ is added so the slot-minus-one never goes negative.
    int unsigned slot;
    int unsigned rot;
    always_comb begin
        slot    = 32'(sw_devfn >> 3);
        rot     = (32'(sw_intx) + slot + NUM_PIRQ - 1) % NUM_PIRQ;
        sw_pirq = PIN_W'(rot);
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_route_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = PIRQ_N,
    parameter int unsigned NUM_IRQ  = IRQ_N,
    parameter int unsigned BASE     = ROUTE_OFF,
    localparam int unsigned PIN_W   = $clog2(NUM_PIRQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PIRQ-1:0]     pirq_lvl,
    input  logic                    cfg_wr,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [NUM_PIRQ-1:0]     cfg_be,
    input  logic [8*NUM_PIRQ-1:0]   cfg_wdata,
    input  logic [CFG_AW-1:0]       cfg_rd_addr,
    output logic [7:0]              cfg_rdata,
    output logic [NUM_IRQ-1:0]      irq_out,
    input  logic [PIN_W-1:0]        q_pin,
    output logic                    q_en,
    output logic [7:0]              q_irq,
    input  logic [7:0]              sw_devfn,
    input  logic [PIN_W-1:0]        sw_intx,
    output logic [PIN_W-1:0]        sw_pirq
);

    route_t [NUM_PIRQ-1:0] route_q;
    route_rsp_t            q_rsp;

    pirq_cfg_regs #(.NUM_PIRQ(NUM_PIRQ), .BASE(BASE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rd_addr (cfg_rd_addr),
        .rdata   (cfg_rdata),
        .routes  (route_q)
    );

    pirq_level_map #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_map (
        .clk     (clk),
        .rst     (rst),
        .lvl     (pirq_lvl),
        .routes  (route_q),
        .irq_out (irq_out)
    );

    pirq_route_query #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) u_query (
        .routes   (route_q),
        .q_pin    (q_pin),
        .q_rsp    (q_rsp),
        .sw_devfn (sw_devfn),
        .sw_intx  (sw_intx),
        .sw_pirq  (sw_pirq)
    );

    assign q_en  = q_rsp.en;
    assign q_irq = q_rsp.irq;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_route_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = PIRQ_N,
    parameter int unsigned NUM_IRQ  = IRQ_N,
    parameter int unsigned BASE     = ROUTE_OFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PIRQ-1:0]     pirq_lvl,
    input  logic [NUM_IRQ-1:0]      irq_out,
    input  route_t [NUM_PIRQ-1:0]   routes,
    input  logic                    cfg_wr,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic                    q_en,
    input  logic [7:0]              q_irq
);

    logic all_off;
    always_comb begin
        all_off = 1'b1;
        for (int i = 0; i < NUM_PIRQ; i++) begin
            if (route_live(routes[i], NUM_IRQ)) all_off = 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_out == '0)); // R1

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && (32'(cfg_addr) != BASE)) |=> $stable(routes)); // R3

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        ($past(pirq_lvl) == '0) |-> (irq_out == '0)); // R4

    AST_ALL_UNROUTED: assert property (@(posedge clk) disable iff (rst)
        ($past(all_off) && !$past(rst)) |-> (irq_out == '0)); // R5

    AST_NO_FANOUT: assert property (@(posedge clk) disable iff (rst)
        ($countones(irq_out) <= $countones($past(pirq_lvl)))); // R6

    AST_QUERY_OFF: assert property (@(posedge clk) disable iff (rst)
        !q_en |-> (q_irq == 8'hFF)); // R8

    AST_QUERY_RANGE: assert property (@(posedge clk) disable iff (rst)
        q_en |-> (32'(q_irq) < NUM_IRQ)); // R8

endmodule

bind pirq_router pirq_router_chk #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .BASE(BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pirq_lvl (pirq_lvl),
    .irq_out  (irq_out),
    .routes   (route_q),
    .cfg_wr   (cfg_wr),
    .cfg_addr (cfg_addr),
    .q_en     (q_en),
    .q_irq    (q_irq)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pirq_lvl = 4'h0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [7:0]  cfg_rd_addr = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] irq_out;
    logic [1:0]  q_pin = 2'd0;
    logic        q_en;
    logic [7:0]  q_irq;
    logic [7:0]  sw_devfn = 8'h00;
    logic [1:0]  sw_intx = 2'd0;
    logic [1:0]  sw_pirq;

    pirq_router dut (
        .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata), .irq_out(irq_out),
        .q_pin(q_pin), .q_en(q_en), .q_irq(q_irq),
        .sw_devfn(sw_devfn), .sw_intx(sw_intx), .sw_pirq(sw_pirq)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    logic [7:0] mr [4];

    function automatic logic [15:0] model(logic [3:0] lv);
        logic [15:0] e = '0;
        for (int p = 0; p < 4; p++) begin
            if (mr[p] < 8'd16 && lv[p]) e[mr[p][3:0]] = 1'b1;
        end
        return e;
    endfunction

    task automatic push(int due, logic [15:0] exp, string tag);
        item_t it;
        it.due = due; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compares irq_out in exactly the cycle each item is due.
    always @(negedge clk) begin
        item_t it;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            n_chk++;
            if (it.due != cyc || irq_out !== it.exp) begin
                n_bad++;
                $display("FAIL %s: irq_out=%h expected=%h (cycle %0d due %0d)",
                         it.tag, irq_out, it.exp, cyc, it.due);
            end
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_lvl(logic [3:0] v, string tag);
        @(negedge clk);
        pirq_lvl = v;
        push(cyc + 1, model(v), tag);
        wait_cyc(2);
    endtask

    task automatic cfg_write(logic [7:0] a, logic [3:0] be, logic [31:0] d, string tag);
        @(negedge clk);
        push(cyc + 1, model(pirq_lvl), {tag, " (old route)"});
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        if (a == 8'h60) begin
            for (int i = 0; i < 4; i++) if (be[i]) mr[i] = d[8*i +: 8];
        end
        push(cyc + 2, model(pirq_lvl), tag);
        @(negedge clk);
        cfg_wr = 1'b0;
        wait_cyc(3);
    endtask

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(logic [7:0] a, logic [7:0] exp, string tag);
        cfg_rd_addr = a;
        #1;
        chk8(tag, cfg_rdata, exp);
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 4; i++) read_chk(8'h60 + 8'(i), mr[i], tag);
    endtask

    task automatic query_chk(logic [1:0] pin);
        logic [7:0] e_irq;
        logic       e_en;
        q_pin = pin;
        #1;
        e_en  = mr[pin] < 8'd16;
        e_irq = e_en ? mr[pin] : 8'hFF;
        chk8("R8 q_en", {7'b0, q_en}, {7'b0, e_en});
        chk8("R8 q_irq", q_irq, e_irq);
    endtask

    task automatic swz_chk(logic [7:0] devfn, logic [1:0] intx, logic [1:0] exp);
        sw_devfn = devfn; sw_intx = intx;
        #1;
        chk8("R9 sw_pirq", {6'b0, sw_pirq}, {6'b0, exp});
    endtask

    task automatic reset_model();
        for (int i = 0; i < 4; i++) mr[i] = 8'h80;
    endtask

    initial begin
        reset_model();
        pirq_lvl = 4'hF;
        wait_cyc(3);
        rst = 1'b0;
        push(cyc + 1, 16'h0000, "R1 reset outputs quiet");
        read_all("R1 reset value");
        wait_cyc(2);

        // R5: all unrouted after reset, levels high
        set_lvl(4'hF, "R5 unrouted after reset");
        set_lvl(4'h0, "R4 idle");

        // R2: full word write: A->3, B->5, C->10, D->11
        cfg_write(8'h60, 4'hF, 32'h0B0A0503, "R2 full write");
        read_all("R2 full write readback");
        set_lvl(4'h1, "R4 line A");
        set_lvl(4'h2, "R4 line B");
        set_lvl(4'hC, "R4 lines C D");
        set_lvl(4'hF, "R4 all lines");
        set_lvl(4'h0, "R4 release");

        // R2: single byte enable moves B to 7
        cfg_write(8'h60, 4'b0010, 32'hEEEE07EE, "R2 byte enable");
        read_all("R2 byte enable readback");
        set_lvl(4'h2, "R4 line B at 7");

        // R3: stray writes ignored; reads outside window return 0
        cfg_write(8'h64, 4'hF, 32'h01010101, "R3 write 0x64");
        cfg_write(8'h5C, 4'hF, 32'h02020202, "R3 write 0x5C");
        cfg_write(8'h61, 4'hF, 32'h04040404, "R3 write 0x61");
        read_all("R3 registers unchanged");
        read_chk(8'h64, 8'h00, "R3 read 0x64");
        read_chk(8'h5F, 8'h00, "R3 read 0x5F");
        set_lvl(4'h2, "R3 output unchanged");

        // R6: A and C share output 9
        cfg_write(8'h60, 4'b0101, 32'h00090009, "R6 share setup");
        set_lvl(4'h1, "R6 only A");
        set_lvl(4'h4, "R6 only C");
        set_lvl(4'h5, "R6 A and C");
        set_lvl(4'h0, "R6 none");

        // R5: disable B with 0x10 and D with 0xFF
        cfg_write(8'h60, 4'b1010, 32'hFF001000, "R5 disable");
        set_lvl(4'hA, "R5 disabled lines ignored");
        query_chk(2'd0); query_chk(2'd1); query_chk(2'd2); query_chk(2'd3);

        // R7: route change with levels held; output 9 falls, 15 rises
        set_lvl(4'h1, "R7 setup");
        cfg_write(8'h60, 4'b0001, 32'h0000000F, "R7 reroute A");
        cfg_write(8'h60, 4'b0001, 32'h00000000, "R7 reroute A to 0");
        query_chk(2'd0);

        // R9: slot helper
        swz_chk(8'h08, 2'd0, 2'd0);
        swz_chk(8'h00, 2'd0, 2'd3);
        swz_chk(8'h1F, 2'd2, 2'd0);
        swz_chk(8'hF8, 2'd3, 2'd1);
        swz_chk(8'h10, 2'd3, 2'd0);

        // R1: reset in mid operation
        set_lvl(4'hF, "R1 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        push(cyc + 1, 16'h0000, "R1 reset clears map");
        reset_model();
        @(negedge clk);
        rst = 1'b0;
        read_all("R1 registers back to 0x80");
        wait_cyc(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule